// File: doc/BRIEF.md
# In-Place Add-One Engine

The block is a memory-mapped processing engine. A one-cycle start pulse while the engine is idle latches a base byte address. The engine then reads a fixed 16 KB region of 32-bit words through an AXI4 master read channel and adds one to every word, wrapping on overflow. It writes each result back through the AXI4 write channel to the address it came from, so the input is overwritten. When the last write response has come back, the engine pulses done and returns to idle.

Reads and writes are split into incrementing bursts of at most 16 beats, and no burst crosses a 4 KB address boundary. Up to four read bursts may be in flight at once. Read data is incremented as it enters a small buffer. A write burst is only requested once every word it needs is already in that buffer. Any response code other than OKAY on either channel raises a sticky error flag, but the run still finishes. Every instance of the engine runs on its own, with its own read side, write side and adder.

Top module: `addone_engine`

## Requirements
- R1: After reset, idle is 1, done is 0, errFlag is 0, and arValid, awValid and wValid are all 0.
- R2: A start pulse seen while idle latches baseAddr, which must be 4-byte aligned. The engine then reads exactly TotalBytes (16384 by default) as consecutive 32-bit words in ascending order from that base, each word once.
- R3: Each word written equals the word read from the same address plus one, modulo 2^32, so 0xFFFFFFFF becomes 0x00000000.
- R4: Write addresses match the read addresses, in ascending order from the base, with every word of the region written exactly once.
- R5: Every burst uses burst code 01 (INCR) and size code 2 (4-byte beats). Its length field is the beat count minus one and is at most 15. No burst crosses a 4096-byte boundary. wLast is 1 exactly on the final beat of each write burst, and an address held valid stays stable until it is accepted.
- R6: At most 4 read bursts are outstanding at any time, counting from acceptance on AR until the rLast beat is accepted.
- R7: Once wValid rises for a burst, it stays high until the last beat of that burst is accepted.
- R8: done is a single-cycle pulse, given exactly once per run and only after every write response has been accepted. idle is 1 in the cycle where done is 1.
- R9: A start pulse while the engine is busy is ignored. The run keeps its original base, and no second run follows.
- R10: A nonzero rResp or bResp sets errFlag. The flag holds through done and is cleared only when the next start is accepted, and the run with the error still completes.
- R11: idle is 0 from the cycle after an accepted start until done, and no AR, AW or W valid is raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, one cycle |
| baseAddr | input | AddrW | Byte address of the region, sampled when start is accepted |
| done | output | 1 | One-cycle completion pulse |
| idle | output | 1 | High when no run is active |
| errFlag | output | 1 | Sticky non-OKAY response indicator |
| arAddr | output | AddrW | Read burst address |
| arLen | output | 8 | Read burst length minus one |
| arSize | output | 3 | Read beat size code |
| arBurst | output | 2 | Read burst type |
| arValid | output | 1 | Read address valid |
| arReady | input | 1 | Read address ready |
| rData | input | DataW | Read data |
| rResp | input | 2 | Read response |
| rLast | input | 1 | Last read beat of burst |
| rValid | input | 1 | Read data valid |
| rReady | output | 1 | Read data ready |
| awAddr | output | AddrW | Write burst address |
| awLen | output | 8 | Write burst length minus one |
| awSize | output | 3 | Write beat size code |
| awBurst | output | 2 | Write burst type |
| awValid | output | 1 | Write address valid |
| awReady | input | 1 | Write address ready |
| wData | output | DataW | Write data |
| wStrb | output | DataW/8 | Write byte enables, all ones |
| wLast | output | 1 | Last write beat of burst |
| wValid | output | 1 | Write data valid |
| wReady | input | 1 | Write data ready |
| bResp | input | 2 | Write response |
| bValid | input | 1 | Write response valid |
| bReady | output | 1 | Write response ready, always high |

## Verification
The bench uses the default parameters: 16 KB per run, 32-bit beats, 16-beat bursts, four outstanding reads and a 64-word buffer. With 4096 beats in each run, the four-burst read limit and the buffer's fill-and-drain behaviour are both reached under throttled ready and valid patterns. One base sits 12 bytes below a 4 KB edge, so it exercises a 3-beat burst followed by aligned bursts. A memory model with all-ones words exercises wraparound, and injected error responses together with a mid-run start pulse exercise the sticky flag and the ignored restart.

// File: rtl/addone_pkg.sv
package addone_pkg;

  // strobes from the control side to the buffer datapath
  typedef struct packed {
    logic push;   // accept one read beat (stored incremented)
    logic pop;    // one write beat consumed
    logic clear;  // empty the buffer at run start
  } dpCtrl_t;

endpackage

// File: rtl/addone_datapath.sv
module addone_datapath
  import addone_pkg::*;
#(
  parameter int DataW = 32,
  parameter int Depth = 64
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpCtrl_t                      ctrl,
  input  logic [DataW-1:0]             inData,
  output logic [DataW-1:0]             outData,
  output logic [$clog2(Depth+1)-1:0]   level
);

  localparam int PtrW = $clog2(Depth);
  localparam int LvlW = $clog2(Depth+1);

  logic [DataW-1:0] store [Depth];
  logic [PtrW-1:0]  wrPtr;
  logic [PtrW-1:0]  rdPtr;

  // increment applied on entry; natural wrap of the adder
  always_ff @(posedge clk) begin
    if (ctrl.push) store[wrPtr] <= inData + DataW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (ctrl.push) wrPtr <= (wrPtr == PtrW'(Depth-1)) ? '0 : wrPtr + PtrW'(1);
      if (ctrl.pop)  rdPtr <= (rdPtr == PtrW'(Depth-1)) ? '0 : rdPtr + PtrW'(1);
      case ({ctrl.push, ctrl.pop})
        2'b10:   level <= level + LvlW'(1);
        2'b01:   level <= level - LvlW'(1);
        default: level <= level;
      endcase
    end
  end

  assign outData = store[rdPtr];

endmodule

// File: rtl/addone_ctrl.sv
module addone_ctrl
  import addone_pkg::*;
#(
  parameter int AddrW          = 32,
  parameter int DataW          = 32,
  parameter int TotalBytes     = 16384,
  parameter int MaxBurst       = 16,
  parameter int MaxOutstanding = 4,
  parameter int FifoDepth      = 64
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic [AddrW-1:0]               baseAddr,
  output logic                           done,
  output logic                           idle,
  output logic                           errFlag,
  output logic [AddrW-1:0]               arAddr,
  output logic [7:0]                     arLen,
  output logic [2:0]                     arSize,
  output logic [1:0]                     arBurst,
  output logic                           arValid,
  input  logic                           arReady,
  input  logic [1:0]                     rResp,
  input  logic                           rLast,
  input  logic                           rValid,
  output logic                           rReady,
  output logic [AddrW-1:0]               awAddr,
  output logic [7:0]                     awLen,
  output logic [2:0]                     awSize,
  output logic [1:0]                     awBurst,
  output logic                           awValid,
  input  logic                           awReady,
  output logic                           wLast,
  output logic                           wValid,
  input  logic                           wReady,
  input  logic [1:0]                     bResp,
  input  logic                           bValid,
  output logic                           bReady,
  input  logic [$clog2(FifoDepth+1)-1:0] level,
  output dpCtrl_t                        dpCtrl
);

  localparam int BeatBytes  = DataW / 8;
  localparam int SizeCode   = $clog2(BeatBytes);
  localparam int TotalBeats = TotalBytes / BeatBytes;
  localparam int BeatCntW   = $clog2(TotalBeats + 1);
  localparam int LenW       = $clog2(MaxBurst + 1);
  localparam int OutW       = $clog2(MaxOutstanding + 1);
  localparam int PageBytes  = 4096;
  localparam int PageBits   = $clog2(PageBytes);

  // beats of the next burst: limited by burst cap, remaining work and page edge
  function automatic logic [LenW-1:0] burstBeats(input logic [AddrW-1:0] a,
                                                 input logic [BeatCntW-1:0] rem);
    int unsigned edgeBeats;
    int unsigned n;
    edgeBeats = (32'(PageBytes) - 32'(a[PageBits-1:0])) >> SizeCode;
    n = 32'(MaxBurst);
    if (edgeBeats < n)  n = edgeBeats;
    if (32'(rem) < n)   n = 32'(rem);
    return LenW'(n);
  endfunction

  logic                running;
  logic [AddrW-1:0]    rdAddr, wrAddr;
  logic [BeatCntW-1:0] rdLeft, wrLeft, bOut;
  logic [OutW-1:0]     rdOut;
  logic [LenW-1:0]     arLenQ, awLenQ, wBeatsLeft, nextRdLen, nextWrLen;
  logic                wActive;
  logic                accept, arIssue, wIssue, rHs, wHs, bHs, finish;

  assign nextRdLen = burstBeats(rdAddr, rdLeft);
  assign nextWrLen = burstBeats(wrAddr, wrLeft);

  assign accept  = start && !running;
  assign rHs     = rValid && rReady;
  assign wHs     = wValid && wReady;
  assign bHs     = bValid && bReady;
  assign arIssue = running && !arValid && (rdLeft != '0) && (rdOut < OutW'(MaxOutstanding));
  // a write burst is requested only when all of its data sits in the buffer
  assign wIssue  = running && !awValid && !wActive && (wrLeft != '0) &&
                   (32'(level) >= 32'(nextWrLen));
  assign finish  = running && (wrLeft == '0) && !awValid && !wActive && (bOut == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running    <= 1'b0;
      done       <= 1'b0;
      errFlag    <= 1'b0;
      rdAddr     <= '0;
      wrAddr     <= '0;
      rdLeft     <= '0;
      wrLeft     <= '0;
      rdOut      <= '0;
      bOut       <= '0;
      arValid    <= 1'b0;
      arAddr     <= '0;
      arLenQ     <= '0;
      awValid    <= 1'b0;
      awAddr     <= '0;
      awLenQ     <= '0;
      wActive    <= 1'b0;
      wBeatsLeft <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        running <= 1'b1;
        errFlag <= 1'b0;
        rdAddr  <= baseAddr;
        wrAddr  <= baseAddr;
        rdLeft  <= BeatCntW'(TotalBeats);
        wrLeft  <= BeatCntW'(TotalBeats);
        rdOut   <= '0;
        bOut    <= '0;
      end else if (running) begin
        // read address channel
        if (arValid && arReady) begin
          arValid <= 1'b0;
        end else if (arIssue) begin
          arValid <= 1'b1;
          arAddr  <= rdAddr;
          arLenQ  <= nextRdLen;
          rdAddr  <= rdAddr + (AddrW'(nextRdLen) << SizeCode);
          rdLeft  <= rdLeft - BeatCntW'(nextRdLen);
        end
        rdOut <= rdOut + OutW'(arIssue) - OutW'(rHs && rLast);
        if (rHs && (rResp != 2'b00)) errFlag <= 1'b1;

        // write address and data
        if (awValid && awReady) awValid <= 1'b0;
        if (wIssue) begin
          awValid    <= 1'b1;
          awAddr     <= wrAddr;
          awLenQ     <= nextWrLen;
          wActive    <= 1'b1;
          wBeatsLeft <= nextWrLen;
          wrAddr     <= wrAddr + (AddrW'(nextWrLen) << SizeCode);
          wrLeft     <= wrLeft - BeatCntW'(nextWrLen);
        end else if (wHs) begin
          wBeatsLeft <= wBeatsLeft - LenW'(1);
          if (wBeatsLeft == LenW'(1)) wActive <= 1'b0;
        end
        bOut <= bOut + BeatCntW'(wIssue) - BeatCntW'(bHs);
        if (bHs && (bResp != 2'b00)) errFlag <= 1'b1;

        if (finish) begin
          done    <= 1'b1;
          running <= 1'b0;
        end
      end
    end
  end

  assign idle    = !running;
  assign arLen   = 8'(arLenQ) - 8'd1;
  assign awLen   = 8'(awLenQ) - 8'd1;
  assign arSize  = 3'(SizeCode);
  assign awSize  = 3'(SizeCode);
  assign arBurst = 2'b01;
  assign awBurst = 2'b01;
  assign rReady  = running && (32'(level) < 32'(FifoDepth));
  assign wValid  = wActive;
  assign wLast   = wActive && (wBeatsLeft == LenW'(1));
  assign bReady  = 1'b1;

  assign dpCtrl.push  = rHs;
  assign dpCtrl.pop   = wHs;
  assign dpCtrl.clear = accept;

endmodule

// File: rtl/addone_engine.sv
module addone_engine #(
  parameter int AddrW          = 32,
  parameter int DataW          = 32,
  parameter int TotalBytes     = 16384,
  parameter int MaxBurst       = 16,
  parameter int MaxOutstanding = 4,
  parameter int FifoDepth      = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [AddrW-1:0]   baseAddr,
  output logic               done,
  output logic               idle,
  output logic               errFlag,
  output logic [AddrW-1:0]   arAddr,
  output logic [7:0]         arLen,
  output logic [2:0]         arSize,
  output logic [1:0]         arBurst,
  output logic               arValid,
  input  logic               arReady,
  input  logic [DataW-1:0]   rData,
  input  logic [1:0]         rResp,
  input  logic               rLast,
  input  logic               rValid,
  output logic               rReady,
  output logic [AddrW-1:0]   awAddr,
  output logic [7:0]         awLen,
  output logic [2:0]         awSize,
  output logic [1:0]         awBurst,
  output logic               awValid,
  input  logic               awReady,
  output logic [DataW-1:0]   wData,
  output logic [DataW/8-1:0] wStrb,
  output logic               wLast,
  output logic               wValid,
  input  logic               wReady,
  input  logic [1:0]         bResp,
  input  logic               bValid,
  output logic               bReady
);

  localparam int LvlW = $clog2(FifoDepth + 1);

  addone_pkg::dpCtrl_t dpCtrl;
  logic [LvlW-1:0]     level;

  addone_ctrl #(
    .AddrW(AddrW), .DataW(DataW), .TotalBytes(TotalBytes),
    .MaxBurst(MaxBurst), .MaxOutstanding(MaxOutstanding), .FifoDepth(FifoDepth)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .done(done), .idle(idle), .errFlag(errFlag),
    .arAddr(arAddr), .arLen(arLen), .arSize(arSize), .arBurst(arBurst),
    .arValid(arValid), .arReady(arReady),
    .rResp(rResp), .rLast(rLast), .rValid(rValid), .rReady(rReady),
    .awAddr(awAddr), .awLen(awLen), .awSize(awSize), .awBurst(awBurst),
    .awValid(awValid), .awReady(awReady),
    .wLast(wLast), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .level(level), .dpCtrl(dpCtrl)
  );

  addone_datapath #(.DataW(DataW), .Depth(FifoDepth)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(dpCtrl),
    .inData(rData), .outData(wData), .level(level)
  );

  assign wStrb = '1;

endmodule

// File: rtl/addone_engine_chk.sv
module addone_engine_chk #(
  parameter int AddrW    = 32,
  parameter int MaxBurst = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             done,
  input logic             idle,
  input logic [AddrW-1:0] arAddr,
  input logic [7:0]       arLen,
  input logic [2:0]       arSize,
  input logic [1:0]       arBurst,
  input logic             arValid,
  input logic             arReady,
  input logic [AddrW-1:0] awAddr,
  input logic [7:0]       awLen,
  input logic [2:0]       awSize,
  input logic [1:0]       awBurst,
  input logic             awValid,
  input logic             awReady,
  input logic             wLast,
  input logic             wValid,
  input logic             wReady
);

  // R5: burst type and length cap on reads
  p_rd_shape_r5: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> (arLen < 8'(MaxBurst)) && (arBurst == 2'b01));

  // R5: read burst stays inside one 4 KB page
  p_rd_page_r5: assert property (@(posedge clk) disable iff (!rstN)
    arValid |-> (13'(arAddr[11:0]) + ((13'(arLen) + 13'd1) << arSize)) <= 13'd4096);

  // R5: write burst type, length cap and page
  p_wr_page_r5: assert property (@(posedge clk) disable iff (!rstN)
    awValid |-> (awLen < 8'(MaxBurst)) && (awBurst == 2'b01) &&
                ((13'(awAddr[11:0]) + ((13'(awLen) + 13'd1) << awSize)) <= 13'd4096));

  // R5: a pending read address holds still
  p_ar_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    arValid && !arReady |=> arValid && $stable(arAddr) && $stable(arLen));

  // R7: no bubble inside a write burst
  p_w_nogap_r7: assert property (@(posedge clk) disable iff (!rstN)
    wValid && !(wReady && wLast) |=> wValid);

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: engine is idle while done shows
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> idle);

  // R11: accepted start leaves idle
  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    idle && start |=> !idle);

  // R11: nothing requested while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    idle |-> !arValid && !awValid && !wValid);

endmodule

bind addone_engine addone_engine_chk #(.AddrW(AddrW), .MaxBurst(MaxBurst)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .idle(idle),
  .arAddr(arAddr), .arLen(arLen), .arSize(arSize), .arBurst(arBurst),
  .arValid(arValid), .arReady(arReady),
  .awAddr(awAddr), .awLen(awLen), .awSize(awSize), .awBurst(awBurst),
  .awValid(awValid), .awReady(awReady),
  .wLast(wLast), .wValid(wValid), .wReady(wReady)
);

// File: tb/test_addone_engine.sv
`timescale 1ns/1ps
module test_addone_engine;

  localparam int Beats = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] baseAddr = '0;
  logic        done, idle, errFlag;
  logic [31:0] arAddr, awAddr, wData;
  logic [7:0]  arLen, awLen;
  logic [2:0]  arSize, awSize;
  logic [1:0]  arBurst, awBurst;
  logic        arValid, awValid, wLast, wValid, rReady, bReady;
  logic [3:0]  wStrb;
  logic        arReady = 1'b0, rLast = 1'b0, rValid = 1'b0, awReady = 1'b0;
  logic        wReady = 1'b0, bValid = 1'b0;
  logic [31:0] rData = '0;
  logic [1:0]  rResp = '0, bResp = '0;

  always #10 clk = ~clk;

  addone_engine i_addone_engine (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .done(done), .idle(idle), .errFlag(errFlag),
    .arAddr(arAddr), .arLen(arLen), .arSize(arSize), .arBurst(arBurst),
    .arValid(arValid), .arReady(arReady),
    .rData(rData), .rResp(rResp), .rLast(rLast), .rValid(rValid), .rReady(rReady),
    .awAddr(awAddr), .awLen(awLen), .awSize(awSize), .awBurst(awBurst),
    .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wLast(wLast), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model
  logic [31:0] mem [logic [31:0]];
  function automatic logic [31:0] memRead(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return (a[4:2] == 3'b111) ? 32'hFFFF_FFFF : a * 32'd3 + 32'd7;
  endfunction

  // scoreboard queues, filled by the driver
  logic [31:0] expAddrQ[$];
  logic [31:0] expDataQ[$];

  // slave model state
  logic [31:0] arAddrQ[$];
  int          arBeatsQ[$];
  logic [31:0] awAddrQ[$];
  int          awBeatsQ[$];
  int          rBeat, wBeat, bPend, bIndex, cyc;
  bit          wInBurst;
  logic [31:0] nextRdAddr, nextAwAddr, curAddr, eAddr, eData;
  int          readBeats, writeBeats, maxOut, doneCount, bCount, awCount;
  bit          injR, injB;
  logic [31:0] errRAddr;
  int          errBIdx;

  // slave driver and monitor: drive at negedge, then resolve the coming edge's handshakes
  initial begin
    cyc = 0; rBeat = 0; wBeat = 0; bPend = 0; bIndex = 0; wInBurst = 0;
    forever begin
      @(negedge clk);
      cyc++;
      arReady = (cyc % 5) != 2;
      awReady = (cyc % 4) != 1;
      wReady  = (awBeatsQ.size() > 0) && ((cyc % 7) != 3);
      if (arAddrQ.size() > 0 && (cyc % 3) != 0) begin
        curAddr = arAddrQ[0] + 32'(rBeat * 4);
        rValid  = 1'b1;
        rData   = memRead(curAddr);
        rLast   = (rBeat == arBeatsQ[0] - 1);
        rResp   = (injR && curAddr == errRAddr) ? 2'b10 : 2'b00;
      end else begin
        rValid = 1'b0; rData = '0; rLast = 1'b0; rResp = 2'b00;
      end
      bValid = (bPend > 0) && (cyc % 2 == 0);
      bResp  = (injB && bIndex == errBIdx) ? 2'b10 : 2'b00;
      #1;
      if (rValid && rReady) begin
        readBeats++;
        if (rLast) begin
          void'(arAddrQ.pop_front());
          void'(arBeatsQ.pop_front());
          rBeat = 0;
        end else rBeat++;
      end
      if (arValid && arReady) begin
        check(arBurst == 2'b01 && arSize == 3'd2 && arLen < 8'd16, "R5", "read burst shape",
              {arBurst, arSize, arLen}, {2'b01, 3'd2, 8'd15});
        check(32'(arAddr[11:0]) + (32'(arLen) + 1) * 4 <= 4096, "R5", "read page crossing",
              arAddr, 32'(arLen));
        check(arAddr == nextRdAddr, "R2", "read address order", arAddr, nextRdAddr);
        nextRdAddr = arAddr + (32'(arLen) + 1) * 4;
        arAddrQ.push_back(arAddr);
        arBeatsQ.push_back(int'(arLen) + 1);
        check(arAddrQ.size() <= 4, "R6", "outstanding reads", arAddrQ.size(), 4);
        if (arAddrQ.size() > maxOut) maxOut = arAddrQ.size();
      end
      if (wInBurst) check(wValid == 1'b1, "R7", "wValid gap inside burst", wValid, 1);
      if (wValid && wReady) begin
        curAddr = awAddrQ[0] + 32'(wBeat * 4);
        if (expAddrQ.size() == 0) begin
          check(1'b0, "R4", "write beyond region", curAddr, 0);
        end else begin
          eAddr = expAddrQ.pop_front();
          eData = expDataQ.pop_front();
          check(curAddr == eAddr, "R4", "write address", curAddr, eAddr);
          check(wData == eData, "R3", "written value", wData, eData);
        end
        check(wLast == (wBeat == awBeatsQ[0] - 1), "R5", "wLast position", wLast,
              (wBeat == awBeatsQ[0] - 1));
        mem[curAddr] = wData;
        writeBeats++;
        if (wLast) begin
          void'(awAddrQ.pop_front());
          void'(awBeatsQ.pop_front());
          wBeat = 0; wInBurst = 0; bPend++;
        end else begin
          wBeat++; wInBurst = 1;
        end
      end
      if (awValid && awReady) begin
        check(awBurst == 2'b01 && awSize == 3'd2 && awLen < 8'd16, "R5", "write burst shape",
              {awBurst, awSize, awLen}, {2'b01, 3'd2, 8'd15});
        check(32'(awAddr[11:0]) + (32'(awLen) + 1) * 4 <= 4096, "R5", "write page crossing",
              awAddr, 32'(awLen));
        check(awAddr == nextAwAddr, "R4", "write burst address", awAddr, nextAwAddr);
        nextAwAddr = awAddr + (32'(awLen) + 1) * 4;
        awAddrQ.push_back(awAddr);
        awBeatsQ.push_back(int'(awLen) + 1);
        awCount++;
      end
      if (bValid && bReady) begin
        bPend--; bIndex++; bCount++;
      end
      if (done) begin
        doneCount++;
        check(bPend == 0 && bCount == awCount && awBeatsQ.size() == 0, "R8",
              "done before all responses", bCount, awCount);
      end
    end
  end

  // driver: load expectations, start a run, wait for it
  task automatic doRun(input logic [31:0] base, input bit withErr, input bit busyPulse);
    nextRdAddr = base; nextAwAddr = base;
    readBeats = 0; writeBeats = 0; maxOut = 0; doneCount = 0; bCount = 0; awCount = 0;
    bIndex = 0; injR = withErr; injB = withErr; errRAddr = base + 32'h100; errBIdx = 2;
    for (int i = 0; i < Beats; i++) begin
      expAddrQ.push_back(base + 32'(i * 4));
      expDataQ.push_back(memRead(base + 32'(i * 4)) + 32'd1);
    end
    @(negedge clk);
    start = 1'b1; baseAddr = base;
    @(negedge clk);
    start = 1'b0;
    check(idle == 1'b0, "R11", "idle after start", idle, 0);
    for (int n = 0; n < 60000 && doneCount == 0; n++) begin
      @(negedge clk);
      if (n == 20) check(idle == 1'b0, "R11", "idle mid-run", idle, 0);
      if (busyPulse && n == 50) begin start = 1'b1; baseAddr = 32'h0004_0000; end
      if (busyPulse && n == 51) start = 1'b0;
    end
    check(doneCount > 0, "R8", "run finished (watchdog)", doneCount, 1);
    repeat (40) @(negedge clk);
    check(doneCount == 1, "R9", "done pulses per run", doneCount, 1);
    check(readBeats == Beats, "R2", "read beat count", readBeats, Beats);
    check(writeBeats == Beats, "R4", "write beat count", writeBeats, Beats);
    check(expAddrQ.size() == 0, "R3", "words left unwritten", expAddrQ.size(), 0);
    check(idle == 1'b1 && arValid == 1'b0, "R11", "idle after done", {idle, arValid}, 2'b10);
    check(errFlag == withErr, "R10", "error flag after run", errFlag, withErr);
    check(maxOut == 4, "R6", "outstanding reads reached", maxOut, 4);
    expAddrQ.delete();
    expDataQ.delete();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(idle == 1'b1 && done == 1'b0 && errFlag == 1'b0, "R1", "reset status",
          {idle, done, errFlag}, 3'b100);
    check(arValid == 1'b0 && awValid == 1'b0 && wValid == 1'b0, "R1", "reset valids",
          {arValid, awValid, wValid}, 0);
    // near-page-edge base: 3-beat first burst, wraparound words inside
    doRun(32'h0000_2FF4, 1'b0, 1'b0);
    check(memRead(32'h0000_2FFC) == 32'h0000_0000, "R3", "all-ones word wraps",
          memRead(32'h0000_2FFC), 0);
    // injected error responses: flag sticks, run completes
    doRun(32'h0000_8000, 1'b1, 1'b0);
    // restart clears the flag; a start while busy is ignored
    doRun(32'h0001_0040, 1'b0, 1'b1);
    check(memRead(32'h0004_0000) == 32'h0004_0000 * 3 + 7, "R9", "ignored base untouched",
          memRead(32'h0004_0000), 32'h0004_0000 * 3 + 7);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog expired: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule